// File: doc/BRIEF.md
# Bidirectional Port with Timer Pin Takeover

This block is an 8-pin general-purpose I/O port that a CPU reaches through two byte-wide registers on a simple register bus. A pin latch holds the value the CPU wants to drive. A direction register chooses, pin by pin, whether the pad drives that value or stays high-impedance. A timer block sits beside the port and can take over the upper five pins. When it does, the timer sets both the driver enable and the level of each pin it owns.

The pin roles are fixed. Pins 0 to 2 receive capture inputs and are never driven by the timer. Pin 3 is shared between one capture input and one compare output. Pins 4 to 6 each carry one compare output. Pin 7 receives the pulse counter input. A master compare channel has a 5-bit mask and can claim any mix of pins 3 to 7. The pad input level can always be read back, whatever drives the pin.

Top module: `gpio_timer_port`

## Requirements
- R1: After a synchronous reset the pin latch and the direction register both hold 0x00 and every pad driver is disabled.
- R2: The direction register sits at bus offset 1. Writes at that offset take effect at the next clock edge, and reads at that offset return the stored value at any time. A 1 bit makes its pin an output.
- R3: Pins 0 to 2 follow only their direction bits and latch bits. No timer input changes their driver enable or level.
- R4: Compare channels 2, 3 and 4 own pins 6, 5 and 4. Channel k is set by `cmp_ctl[2*(k-2)+1 : 2*(k-2)]` and its level by `cmp_lvl[k-2]`. A field of 00 leaves the pin under direction and latch control. Any nonzero field enables the driver and drives the channel level, whatever the direction bit says.
- R5: Compare channel 5 uses field `cmp_ctl[7:6]` and level `cmp_lvl[3]` on pin 3. It drives pin 3 only while `cap4_sel` is 0. While `cap4_sel` is 1, pin 3 is under direction and latch control.
- R6: Each set bit j of `mst_mask` claims pin 3+j, enables its driver and drives `mst_lvl[j]`. On a shared pin this wins over the other compare channel.
- R7: `pacc_en` has no effect on pin 7. Pin 7 is still driven by the master channel, or as a general-purpose output when its direction bit is set.
- R8: A read at offset 0 returns `pad_out` for each pin whose driver is enabled and `pin_in` for each other pin.
- R9: A write at offset 0 always updates the latch. The latch reaches a pin only while that pin is a general-purpose output that no timer channel owns. When a timer releases the pin, the stored latch value appears on it.
- R10: Writes at offsets 2 and 3 change nothing. Reads at those offsets return 0x00, and `bus_rdata` is 0x00 whenever `bus_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| cmp_ctl | input | 8 | Control fields of compare channels 2 to 5 |
| cmp_lvl | input | 4 | Levels of compare channels 2 to 5 |
| mst_mask | input | 5 | Master channel pin mask for pins 3 to 7 |
| mst_lvl | input | 5 | Master channel levels for pins 3 to 7 |
| cap4_sel | input | 1 | 1 selects capture on pin 3, 0 selects compare 5 |
| pacc_en | input | 1 | Pulse counter enable |
| pin_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad driver enables |
| pad_out | output | 8 | Pad output levels |

## Verification
A corrupted direction register or latch shows up at `pad_oe` or `pad_out` in the same cycle the bad value is stored. It also shows up on a read at offset 1 or offset 0 with no added delay, because the pin mux and the read path are purely combinational. An ownership error in the pin mux shows up at once on the pads. Such an error is masked only while the wrong owner happens to drive the same level, so the stimulus gives the latch and the timer levels opposite values on each pin under test.

// File: rtl/gpt_pkg.sv
// Shared constants of the timer-aware port: register offsets and pin layout.
// Assumes an 8-pin port whose upper five pins can be taken by the timer.
package gpt_pkg;
    localparam int PORT_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int UPPER_LO = 3;                    // first timer-ownable pin
    localparam int N_UPPER  = PORT_W - UPPER_LO;    // pins the master may claim
    localparam int N_CMP    = 4;                    // compare channels 2..5
    localparam int CTL_W    = 2 * N_CMP;
    localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 2'd1;

    // Index of the compare channel (0 = channel 2) wired to upper pin j,
    // or -1 when the pin has no dedicated compare channel.
    function automatic int cmp_of_upper(input int j);
        return (j < N_CMP) ? (N_CMP - 1 - j) : -1;
    endfunction
endpackage

// File: rtl/gpt_regs.sv
// Holds the pin latch and the direction register, written over the bus.
// Assumes single-cycle write strobes; unmapped offsets are dropped.
module gpt_regs
    import gpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] dir_q
);
    // Pin latch: always takes a write at the data offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (wr_en && addr == OFS_DATA)
            latch_q <= wdata;
    end

    // Direction register: takes a write at its own offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr_en && addr == OFS_DIR)
            dir_q <= wdata;
    end

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DIR) |=> dir_q == $past(wdata));

    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_DATA) |=> $stable(latch_q));

    assert_latch_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DATA) |=> latch_q == $past(wdata));
endmodule

// File: rtl/gpt_pinmux.sv
// Chooses, for each pin, who owns the driver: direction/latch or a timer channel.
// Assumes the master mask outranks every dedicated compare channel.
module gpt_pinmux
    import gpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PORT_W-1:0]  dir_q,
    input  logic [PORT_W-1:0]  latch_q,
    input  logic [CTL_W-1:0]   cmp_ctl,
    input  logic [N_CMP-1:0]   cmp_lvl,
    input  logic [N_UPPER-1:0] mst_mask,
    input  logic [N_UPPER-1:0] mst_lvl,
    input  logic               cap4_sel,
    input  logic               pacc_en,
    output logic [PORT_W-1:0]  pad_oe,
    output logic [PORT_W-1:0]  pad_out
);
    logic [N_UPPER-1:0] tmr_own;
    logic [N_UPPER-1:0] tmr_lvl;

    // Capture-only pins: plain general-purpose behaviour.
    always_comb begin
        pad_oe[UPPER_LO-1:0]  = dir_q[UPPER_LO-1:0];
        pad_out[UPPER_LO-1:0] = latch_q[UPPER_LO-1:0];
    end

    for (genvar j = 0; j < N_UPPER; j++) begin : g_upper
        localparam int CH = cmp_of_upper(j);
        logic ch_own;
        logic ch_lvl;
        if (CH >= 0) begin : g_cmp
            if (j == 0) begin : g_shared
                // Shared pin: the compare channel counts only when capture is not selected.
                always_comb ch_own = (cmp_ctl[2*CH +: 2] != 2'b00) && !cap4_sel;
            end else begin : g_plain
                // Dedicated compare pin: any nonzero field claims it.
                always_comb ch_own = (cmp_ctl[2*CH +: 2] != 2'b00);
            end
            always_comb ch_lvl = cmp_lvl[CH];
        end else begin : g_none
            // Pulse counter pin: no dedicated compare channel.
            always_comb begin
                ch_own = 1'b0;
                ch_lvl = 1'b0;
            end
        end

        // Merge master and dedicated channel; the master wins.
        always_comb begin
            tmr_own[j] = mst_mask[j] | ch_own;
            tmr_lvl[j] = mst_mask[j] ? mst_lvl[j] : ch_lvl;
        end

        // Drive the pad from the timer when owned, else from direction/latch.
        always_comb begin
            pad_oe[UPPER_LO+j]  = tmr_own[j] | dir_q[UPPER_LO+j];
            pad_out[UPPER_LO+j] = tmr_own[j] ? tmr_lvl[j] : latch_q[UPPER_LO+j];
        end
    end

    assert_lower_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(dir_q[UPPER_LO-1:0]) && $stable(latch_q[UPPER_LO-1:0])
        |-> $stable(pad_oe[UPPER_LO-1:0]) && $stable(pad_out[UPPER_LO-1:0]));

    assert_master_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mst_mask[1] |-> pad_oe[UPPER_LO+1] && pad_out[UPPER_LO+1] == mst_lvl[1]);

    assert_cap4_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap4_sel && !mst_mask[0] && !dir_q[UPPER_LO]) |-> !pad_oe[UPPER_LO]);

    assert_pacc_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pacc_en && dir_q[PORT_W-1]) |-> pad_oe[PORT_W-1]);

    assert_cmp2_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_ctl[1:0] != 2'b00 && !mst_mask[N_UPPER-2])
        |-> pad_oe[PORT_W-2] && pad_out[PORT_W-2] == cmp_lvl[0]);
endmodule

// File: rtl/gpt_readback.sv
// Read path: returns sensed pin levels or driver levels, and the direction register.
// Assumes combinational reads qualified by the read strobe.
module gpt_readback
    import gpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] pad_oe,
    input  logic [PORT_W-1:0] pad_out,
    input  logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] rdata
);
    logic [PORT_W-1:0] sensed;

    // Per-pin choice between driver level and pad level.
    always_comb sensed = (pad_oe & pad_out) | (~pad_oe & pin_in);

    // Offset decode of the read data.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_DATA: rdata = sensed;
                OFS_DIR:  rdata = dir_q;
                default:  rdata = '0;
            endcase
        end
    end

    assert_input_sense_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_DATA) |-> (rdata & ~pad_oe) == (pin_in & ~pad_oe));

    assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);
endmodule

// File: rtl/gpio_timer_port.sv
// Top of the timer-aware 8-pin port: register bank, pin mux and read path.
// Assumes the timer inputs are synchronous to clk.
module gpio_timer_port
    import gpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [PORT_W-1:0]  bus_wdata,
    output logic [PORT_W-1:0]  bus_rdata,
    input  logic [CTL_W-1:0]   cmp_ctl,
    input  logic [N_CMP-1:0]   cmp_lvl,
    input  logic [N_UPPER-1:0] mst_mask,
    input  logic [N_UPPER-1:0] mst_lvl,
    input  logic               cap4_sel,
    input  logic               pacc_en,
    input  logic [PORT_W-1:0]  pin_in,
    output logic [PORT_W-1:0]  pad_oe,
    output logic [PORT_W-1:0]  pad_out
);
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;

    gpt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr_en),
        .wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q)
    );

    gpt_pinmux u_mux (
        .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .latch_q(latch_q),
        .cmp_ctl(cmp_ctl), .cmp_lvl(cmp_lvl), .mst_mask(mst_mask),
        .mst_lvl(mst_lvl), .cap4_sel(cap4_sel), .pacc_en(pacc_en),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    gpt_readback u_rd (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd_en(bus_rd_en),
        .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .dir_q(dir_q),
        .rdata(bus_rdata)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pad_oe == '0);
endmodule

// File: tb/sim_gpio_timer_port.sv
`timescale 1ns/100ps
module sim_gpio_timer_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr_en = 1'b0;
    logic       bus_rd_en = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] cmp_ctl = '0;
    logic [3:0] cmp_lvl = '0;
    logic [4:0] mst_mask = '0;
    logic [4:0] mst_lvl = '0;
    logic       cap4_sel = 1'b0;
    logic       pacc_en = 1'b0;
    logic [7:0] pin_in = '0;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_timer_port u0 (.*);

    typedef struct packed {
        logic [7:0] dir, lat, ctl;
        logic [3:0] clvl;
        logic [4:0] mask, mlvl;
        logic       sel, pacc;
        logic [7:0] pins, eoe, eout, erd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'hA5, 8'h00, 4'h0, 5'h00, 5'h00, 1'b0, 1'b0, 8'h3C, 8'h00, 8'hA5, 8'h3C}, // idle inputs
        '{8'hFF, 8'hA5, 8'h00, 4'h0, 5'h00, 5'h00, 1'b0, 1'b0, 8'h00, 8'hFF, 8'hA5, 8'hA5}, // all outputs
        '{8'h0F, 8'h5A, 8'h31, 4'h1, 5'h00, 5'h00, 1'b0, 1'b0, 8'hF0, 8'h5F, 8'h4A, 8'hEA}, // ch2, ch4 (R4)
        '{8'h00, 8'h00, 8'h80, 4'h8, 5'h00, 5'h00, 1'b1, 1'b0, 8'h08, 8'h00, 8'h00, 8'h08}, // capture sel (R5)
        '{8'h00, 8'h00, 8'h80, 4'h8, 5'h00, 5'h00, 1'b0, 1'b0, 8'h00, 8'h08, 8'h08, 8'h08}, // ch5 drives (R5)
        '{8'h00, 8'hFF, 8'h04, 4'h2, 5'h16, 5'h02, 1'b0, 1'b1, 8'h00, 8'hB0, 8'h5F, 8'h10}, // master wins (R6)
        '{8'h80, 8'h80, 8'h00, 4'h0, 5'h00, 5'h00, 1'b0, 1'b1, 8'h00, 8'h80, 8'h80, 8'h80}, // pacc + gp out (R7)
        '{8'h00, 8'h07, 8'hFF, 4'hF, 5'h1F, 5'h00, 1'b0, 1'b0, 8'h05, 8'hF8, 8'h07, 8'h05}  // lower ignore (R3)
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd_en = 1'b1;
        #1 d = bus_rdata;
        bus_rd_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        pin_in = 8'hC3;
        #1;
        check("R1 reset oe", pad_oe, 8'h00);
        bus_read(2'd1, rd); check("R1 reset dir", rd, 8'h00);
        bus_read(2'd0, rd); check("R1 reset read pins", rd, 8'hC3);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            bus_write(2'd0, VECS[i].lat);
            bus_write(2'd1, VECS[i].dir);
            cmp_ctl = VECS[i].ctl; cmp_lvl = VECS[i].clvl;
            mst_mask = VECS[i].mask; mst_lvl = VECS[i].mlvl;
            cap4_sel = VECS[i].sel; pacc_en = VECS[i].pacc; pin_in = VECS[i].pins;
            #1;
            check($sformatf("R4/R8 vec%0d oe", i), pad_oe, VECS[i].eoe);
            check($sformatf("R4/R9 vec%0d out", i), pad_out, VECS[i].eout);
            bus_read(2'd0, rd); check($sformatf("R8 vec%0d read", i), rd, VECS[i].erd);
            bus_read(2'd1, rd); check($sformatf("R2 vec%0d dir", i), rd, VECS[i].dir);
        end

        // R9: latch written while ch2 owns pin 6 does not reach the pin until release.
        cmp_ctl = 8'h02; cmp_lvl = 4'h0; mst_mask = '0; cap4_sel = 1'b0; pacc_en = 1'b0;
        bus_write(2'd1, 8'h40);
        bus_write(2'd0, 8'h40);
        #1 check("R9 owned pin keeps timer level", pad_out & 8'h40, 8'h00);
        cmp_ctl = 8'h00;
        #1 check("R9 release shows latch", pad_out & 8'h40, 8'h40);

        // R10: unmapped offsets.
        bus_write(2'd2, 8'hFF);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd1, rd); check("R10 dir untouched", rd, 8'h40);
        #1 check("R10 latch untouched", pad_out, 8'h40);
        bus_read(2'd2, rd); check("R10 unmapped read", rd, 8'h00);
        bus_addr = 2'd1; #1 check("R10 idle read", bus_rdata, 8'h00);

        // R1: synchronous reset mid-run.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 check("R1 mid-run reset oe", pad_oe, 8'h00);
        bus_read(2'd1, rd); check("R1 mid-run reset dir", rd, 8'h00);
        check("R1 mid-run reset latch", pad_out, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule